// File: doc/BRIEF.md
# Alternating Two-Output PWM With Ramp-Fall Deadtime

This block generates gate commands for a bridge power stage from a digital sawtooth. A counter climbs for a fixed number of clocks (the rise) and then descends for a second fixed number of clocks (the fall). Both counts are parameters. Every pass through the sawtooth is one oscillator period. During the fall both gate commands are held low, so the fall length sets the deadtime between the two switches. A toggle register sends each period's pulse to one of the two outputs in turn. One full bridge switching cycle therefore spans two oscillator periods.

Each pulse begins at the bottom of the ramp. It ends when the rising count reaches a limit that is four fifths of the smaller of two level codes: an error code from the control loop and a soft-start code. Both codes are captured only at the bottom of the ramp. An overcurrent flag removes the active pulse in the same clock. The pulse then stays off for the rest of that period, and this memory is cleared at the end of the period. While the enable input is low, both outputs are off and the oscillator is parked at the bottom of the ramp. The toggle is also reset, so the next enabled pulse appears on output A.

Top module: `dtpwm_core`

## Requirements
- R1: With enable high, one period lasts CHG_CYC + DIS_CYC clocks (20 + 4 by default). `cyc_start` is high only on the first clock of each period.
- R2: In the last DIS_CYC clocks of every period, `out_a` and `out_b` are both low.
- R3: Periods alternate between output A and output B. The first period after reset or after enable rises drives A.
- R4: `out_a` and `out_b` are never high in the same clock.
- R5: Let L = floor(min(err, ss) * 4 / 5), where err and ss are the captured 8-bit codes. In each period the selected output is high for the first min(CHG_CYC, L) clocks, absent overcurrent. With both codes at 255, the duty is therefore CHG_CYC out of each period.
- R6: An error code that gives L = 0 (codes 0 or 1) produces no pulse at all.
- R7: A soft-start code lower than the error code sets the limit on its own.
- R8: When `oc_flag` is high in a rising clock, the active output goes low in that same clock. It stays low until the period ends, even after the flag clears.
- R9: The overcurrent memory is cleared at the end of each period, so the next period has a normal pulse.
- R10: While `en` is low, `out_a`, `out_b` and `cyc_start` are low in the same clock.
- R11: The codes are captured on the last clock of a period and while `en` is low. A code change in the middle of a period does not alter that period's pulse.
- R12: While `rst` is high (with `en` low), all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low parks the ramp and silences outputs |
| err_code | input | 8 | Control loop level code |
| ss_code | input | 8 | Soft-start level code |
| oc_flag | input | 1 | Overcurrent detected |
| out_a | output | 1 | Gate command, first phase |
| out_b | output | 1 | Gate command, second phase |
| cyc_start | output | 1 | One-clock strobe at the bottom of the ramp |

## Verification
On every cycle, the assertions check the following: the two outputs are never high together; both are silent during the fall and while disabled; the toggle flips at each period end; the fall runs its full count; the overcurrent memory persists to the period end; and the captured codes stay unchanged between captures. Only the bench scenarios can show the pulse width against each code, the zero-duty and soft-start limits, the order of A before B after enable, and whether a mid-period code change waits for the next valley. To do this, the bench compares the outputs against a behavioural reference on every clock and counts pulse lengths per period.

// File: rtl/dtpwm_pkg.sv
package dtpwm_pkg;

    parameter int unsigned LVL_W = 8;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic {
        PH_RISE = 1'b0,
        PH_FALL = 1'b1
    } ramp_ph_e;

    typedef struct packed {
        lvl_t err;
        lvl_t ss;
    } lvl_pair_t;

    // Limit is four fifths of the lower of the two captured levels.
    function automatic lvl_t limit_of(lvl_pair_t p);
        logic [LVL_W+2:0] m;
        logic [LVL_W+2:0] five;
        five = (LVL_W+3)'(5);
        m    = (p.err < p.ss) ? {3'b000, p.err} : {3'b000, p.ss};
        return lvl_t'((m << 2) / five);
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dtpwm_ramp.sv
module dtpwm_ramp
    import dtpwm_pkg::*;
#(
    parameter int unsigned CHG_CYC = 20,
    parameter int unsigned DIS_CYC = 4,
    localparam int unsigned CNT_W  = $clog2(max2(CHG_CYC, DIS_CYC) + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output ramp_ph_e         phase,
    output logic [CNT_W-1:0] cnt,
    output logic             valley,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] RISE_LAST = CNT_W'(CHG_CYC - 1);
    localparam logic [CNT_W-1:0] FALL_TOP  = CNT_W'(DIS_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= PH_RISE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_RISE: begin
                    if (cnt == RISE_LAST) begin
                        phase <= PH_FALL;
                        cnt   <= FALL_TOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_FALL: begin
                    if (cnt == '0) begin
                        phase <= PH_RISE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    phase <= PH_RISE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign valley = (phase == PH_RISE) && (cnt == '0);
    assign wrap   = (phase == PH_FALL) && (cnt == '0);

    // R1: the fall runs down to zero without leaving early
    p_fall_runs_r1: assert property (@(posedge clk) disable iff (rst)
        (run && phase == PH_FALL && cnt != '0) |=> (phase == PH_FALL));

    // R1: top of the rise hands over to a full-length fall
    p_rise_top_r1: assert property (@(posedge clk) disable iff (rst)
        (run && phase == PH_RISE && cnt == RISE_LAST) |=>
        (phase == PH_FALL && cnt == FALL_TOP));

endmodule

// File: rtl/dtpwm_steer.sv
module dtpwm_steer (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wrap,
    output logic sel_b
);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sel_b <= 1'b0;
        end else if (wrap) begin
            sel_b <= ~sel_b;
        end
    end

    // R3: each period end hands the next pulse to the other output
    p_alternate_r3: assert property (@(posedge clk) disable iff (rst)
        (run && wrap) |=> (sel_b != $past(sel_b)));

    // R3: disable returns steering to output A
    p_home_a_r3: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> (!sel_b));

endmodule

// File: rtl/dtpwm_limit.sv
module dtpwm_limit
    import dtpwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     wrap,
    input  ramp_ph_e phase,
    input  lvl_t     err_in,
    input  lvl_t     ss_in,
    input  logic     oc_in,
    output lvl_t     thr,
    output logic     blocked
);

    lvl_pair_t cap;
    logic      oc_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else if (!run || wrap) begin
            cap <= '{err: err_in, ss: ss_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || wrap) begin
            oc_lat <= 1'b0;
        end else if (phase == PH_RISE && oc_in) begin
            oc_lat <= 1'b1;
        end
    end

    assign thr     = limit_of(cap);
    assign blocked = oc_lat || oc_in;

    // R11: captured codes only move at a period end or while parked
    p_hold_codes_r11: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> $stable(cap));

    // R8: the overcurrent memory lasts until the period ends
    p_oc_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (run && oc_lat && !wrap) |=> oc_lat);

    // R9: the period end clears the overcurrent memory
    p_oc_blank_r9: assert property (@(posedge clk) disable iff (rst)
        (wrap) |=> !oc_lat);

endmodule

// File: rtl/dtpwm_core.sv
module dtpwm_core
    import dtpwm_pkg::*;
#(
    parameter int unsigned CHG_CYC = 20,
    parameter int unsigned DIS_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LVL_W-1:0] err_code,
    input  logic [LVL_W-1:0] ss_code,
    input  logic             oc_flag,
    output logic             out_a,
    output logic             out_b,
    output logic             cyc_start
);

    localparam int unsigned CNT_W = $clog2(max2(CHG_CYC, DIS_CYC) + 1);
    localparam int unsigned CMP_W = max2(CNT_W, LVL_W);

    ramp_ph_e         phase;
    logic [CNT_W-1:0] cnt;
    logic             valley;
    logic             wrap;
    logic             sel_b;
    lvl_t             thr;
    logic             blocked;
    logic [CMP_W-1:0] cnt_x;
    logic [CMP_W-1:0] thr_x;
    logic             gate;

    dtpwm_ramp #(.CHG_CYC(CHG_CYC), .DIS_CYC(DIS_CYC)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .run    (en),
        .phase  (phase),
        .cnt    (cnt),
        .valley (valley),
        .wrap   (wrap)
    );

    dtpwm_steer u_steer (
        .clk   (clk),
        .rst   (rst),
        .run   (en),
        .wrap  (wrap),
        .sel_b (sel_b)
    );

    dtpwm_limit u_limit (
        .clk     (clk),
        .rst     (rst),
        .run     (en),
        .wrap    (wrap),
        .phase   (phase),
        .err_in  (err_code),
        .ss_in   (ss_code),
        .oc_in   (oc_flag),
        .thr     (thr),
        .blocked (blocked)
    );

    assign cnt_x = CMP_W'(cnt);
    assign thr_x = CMP_W'(thr);
    assign gate  = en && (phase == PH_RISE) && (cnt_x < thr_x) && !blocked;

    assign out_a     = gate && !sel_b;
    assign out_b     = gate &&  sel_b;
    assign cyc_start = en && valley;

    // R4: the two gate commands never overlap
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        !(out_a && out_b));

    // R2: the ramp fall is dead time for both outputs
    p_dead_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FALL) |-> (!out_a && !out_b));

    // R10: a low enable silences every output
    p_parked_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!en) |-> (!out_a && !out_b && !cyc_start));

endmodule

// File: tb/sim_dtpwm_core.sv
module sim_dtpwm_core;
    localparam int CHG = 20;
    localparam int DIS = 4;
    localparam int PER = CHG + DIS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [7:0] err_code = 8'd0;
    logic [7:0] ss_code = 8'd0;
    logic       oc_flag = 1'b0;
    logic       out_a, out_b, cyc_start;

    int checks = 0;
    int failures = 0;
    bit chk_on = 0;
    bit done = 0;
    string cur_req = "R5";

    // reference model state
    int pos = 0, mtog = 0, me = 0, ms = 0, moc = 0;

    always #5 clk = ~clk;

    dtpwm_core #(.CHG_CYC(CHG), .DIS_CYC(DIS)) u0 (
        .clk(clk), .rst(rst), .en(en), .err_code(err_code), .ss_code(ss_code),
        .oc_flag(oc_flag), .out_a(out_a), .out_b(out_b), .cyc_start(cyc_start)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            pos = 0; mtog = 0; me = 0; ms = 0; moc = 0;
        end else if (!en) begin
            pos = 0; mtog = 0; me = err_code; ms = ss_code; moc = 0;
        end else begin
            if (pos < CHG && oc_flag) moc = 1;
            if (pos == PER - 1) begin
                pos = 0; mtog = mtog ^ 1; moc = 0; me = err_code; ms = ss_code;
            end else begin
                pos++;
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            int lim;
            bit on;
            lim = (((me < ms) ? me : ms) * 4) / 5;
            on  = en && pos < CHG && pos < lim && !moc && !oc_flag;
            chk(cur_req, out_a, on && mtog == 0, "model out_a");
            chk(cur_req, out_b, on && mtog == 1, "model out_b");
            chk("R1", cyc_start, en && pos == 0, "model cyc_start");
        end
    end

    // measures one period from the next strobe; optional overcurrent and code change
    task automatic run_period(input int oc_at, input int chg_at, input int new_err,
                              output int na, output int nb, output int ndead);
        na = 0; nb = 0; ndead = 0;
        do @(negedge clk); while (cyc_start !== 1'b1);
        for (int i = 0; i < PER; i++) begin
            if (i > 0) @(negedge clk);
            chk("R1", cyc_start, (i == 0), "strobe position");
            na += out_a;
            nb += out_b;
            if (i >= CHG && (out_a || out_b)) ndead++;
            if (i == oc_at) begin
                #1 oc_flag = 1'b1;
                #2 chk("R8", out_a | out_b, 0, "output same clock as overcurrent");
            end
            if (i == oc_at + 1) #1 oc_flag = 1'b0;
            if (i == chg_at) #1 err_code = 8'(new_err);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int na, nb, nd;
        repeat (3) @(negedge clk);
        chk("R12", out_a, 0, "reset out_a");
        chk("R12", out_b, 0, "reset out_b");
        chk("R12", cyc_start, 0, "reset cyc_start");
        @(posedge clk); #1 rst = 1'b0;
        err_code = 8'd255; ss_code = 8'd255;
        chk_on = 1;
        @(posedge clk); #1 en = 1'b1;

        // full duty, A then B
        cur_req = "R5";
        run_period(-1, -1, 0, na, nb, nd);
        chk("R5", na, CHG, "max duty width on A");
        chk("R3", nb, 0, "first period on A");
        chk("R2", nd, 0, "dead fall clocks");
        run_period(-1, -1, 0, na, nb, nd);
        chk("R3", nb, CHG, "second period on B");
        chk("R4", na, 0, "A silent while B drives");

        // mid-period code change waits for the valley
        cur_req = "R11";
        run_period(-1, 5, 10, na, nb, nd);
        chk("R11", na + nb, CHG, "width unchanged after mid-period code");
        cur_req = "R5";
        run_period(-1, -1, 0, na, nb, nd);
        chk("R5", na + nb, 8, "width for err=10 (L=8)");
        chk("R2", nd, 0, "dead fall clocks");

        // zero duty
        cur_req = "R6";
        run_period(-1, 5, 1, na, nb, nd);
        run_period(-1, -1, 0, na, nb, nd);
        chk("R6", na + nb, 0, "no pulse for err=1");

        // soft-start limit
        cur_req = "R7";
        #1 ss_code = 8'd5;
        run_period(-1, 5, 200, na, nb, nd);
        run_period(-1, -1, 0, na, nb, nd);
        chk("R7", na + nb, 4, "soft-start 5 limits width to 4");

        // overcurrent truncation and blanking
        cur_req = "R8";
        #1 ss_code = 8'd255;
        run_period(-1, 5, 255, na, nb, nd);
        run_period(6, -1, 0, na, nb, nd);
        chk("R8", na + nb, 7, "pulse cut by overcurrent at clock 6");
        cur_req = "R9";
        run_period(-1, -1, 0, na, nb, nd);
        chk("R9", na + nb, CHG, "full pulse after blanking");

        // enable drop mid pulse
        cur_req = "R10";
        do @(negedge clk); while (cyc_start !== 1'b1);
        repeat (3) @(negedge clk);
        #1 en = 1'b0;
        #2 chk("R10", out_a | out_b | cyc_start, 0, "outputs low same clock as disable");
        repeat (5) @(negedge clk);
        chk("R10", out_a | out_b | cyc_start, 0, "outputs low while parked");
        @(posedge clk); #1 en = 1'b1;
        run_period(-1, -1, 0, na, nb, nd);
        chk("R10", na, CHG, "A drives first after re-enable");
        chk("R3", nb, 0, "B silent on first period after enable");

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule